// File: doc/BRIEF.md
# Synchronous-RAM FIFO with Head Bypass

This block is a first-in first-out queue whose storage is a dual-port memory with one write port and one registered read port, where read data appears one clock after the address is presented. Despite that latency, the oldest stored word is always present on `data_o` whenever the queue is not empty. A consumer can therefore pop on any cycle without waiting for the memory.

Two mechanisms hide the latency. The read address given to the memory is always the read pointer as it will be after the current cycle. A FIFO knows this address in advance: it is the read pointer plus one on a pop, and the read pointer itself otherwise. The other case is a push whose word becomes the head in the next cycle. This happens on a push into an empty queue, or a push together with a pop when one word is held. The memory cannot return that word in time, so a bypass register captures it and drives the output for that one cycle.

Top module: `sync_ram_fifo`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `count_o` is 0.
- R2: Whenever `empty_o` is 0, `data_o` equals the oldest accepted word not yet popped. It stays unchanged while no pop and no flush occur.
- R3: A word pushed into an empty queue is on `data_o` in the cycle after the push. It can be popped in that cycle, and each following word appears on the next cycle with no gap.
- R4: At each clock edge, an accepted push alone raises `count_o` by 1 and an accepted pop alone lowers it by 1. An accepted push and pop in the same cycle leave it unchanged.
- R5: `full_o` is 1 exactly when `count_o` equals DEPTH. `empty_o` is 1 exactly when `count_o` is 0.
- R6: A push while `full_o` is 1 is ignored: the count and the stored sequence are unchanged. This holds even when a pop is accepted in the same cycle.
- R7: A pop while `empty_o` is 1 is ignored and leaves the count unchanged.
- R8: With exactly one word held, a simultaneous push and pop leaves the pushed word on `data_o` in the next cycle, with `count_o` still 1.
- R9: `flush_i` empties the queue in one cycle, with `count_o` 0 and `empty_o` 1 afterwards. It overrides any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all contents |
| push_i | input | 1 | Write `data_i` to the tail |
| data_i | input | DATA_W | Word to push |
| pop_i | input | 1 | Remove the head word |
| data_o | output | DATA_W | Current head word, valid while `empty_o` is 0 |
| full_o | output | 1 | Queue holds DEPTH words |
| empty_o | output | 1 | Queue holds no words |
| count_o | output | $clog2(DEPTH)+1 | Number of words held |

## Verification
A read address that lags by one entry shows up as `data_o` holding the previous or stale word on the first cycle after a pop. The reference queue catches it in that same cycle. A bypass select that is set wrongly, or held one cycle too long, shows up as a wrong head right after a push into an empty or one-entry queue. It also shows up as a word repeated on the following cycle. Pointer or wrap-bit faults make `count_o` and the flags disagree with the model at the first boundary crossing, which is at latest one full burst of DEPTH pushes.

// File: rtl/sync_ram_fifo_pkg.sv
package sync_ram_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_ops_t;
endpackage

// File: rtl/srf_mem.sv
module srf_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  // registered read, returns old data on same-address write
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/srf_ptrs.sv
module srf_ptrs
  import sync_ram_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  output fifo_ops_t     ops_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_next_addr_o,
  output logic          head_hit_o,
  output logic [PW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [PW-1:0] wr_ptr_d, rd_ptr_d;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign count_o = wr_ptr_q - rd_ptr_q;

  assign ops_o.push = push_i & ~full_o & ~flush_i;
  assign ops_o.pop  = pop_i & ~empty_o & ~flush_i;

  assign wr_ptr_d = wr_ptr_q + {{AW{1'b0}}, ops_o.push};
  assign rd_ptr_d = rd_ptr_q + {{AW{1'b0}}, ops_o.pop};

  assign wr_addr_o      = wr_ptr_q[AW-1:0];
  assign rd_next_addr_o = rd_ptr_d[AW-1:0];
  // word being written is the next head: memory cannot deliver it in time
  assign head_hit_o     = ops_o.push && (rd_ptr_d == wr_ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !(pop_i && !empty_o) && !flush_i) |=> (count_o == $past(count_o) + 1'b1)) // R4
    else $error("count did not rise");
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !(push_i && !full_o) && !flush_i) |=> (count_o == $past(count_o) - 1'b1)) // R4
    else $error("count did not fall");
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o) // R6
    else $error("push while full changed state");
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o) // R7
    else $error("pop while empty changed state");
  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && count_o == '0)) // R9
    else $error("flush did not clear");
endmodule

// File: rtl/srf_head.sv
module srf_head #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic              byp_sel_q;
  logic [DATA_W-1:0] byp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byp_sel_q <= 1'b0;
    else if (flush_i) byp_sel_q <= 1'b0;
    else              byp_sel_q <= hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    byp_data_q <= '0;
    else if (hit_i) byp_data_q <= data_i;
  end

  assign data_o = byp_sel_q ? byp_data_q : mem_rdata_i;

  AST_BYP_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !flush_i) |=> (data_o == $past(data_i))) // R3
    else $error("bypass word not on output");
endmodule

// File: rtl/sync_ram_fifo.sv
module sync_ram_fifo
  import sync_ram_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o
);
  fifo_ops_t         ops;
  logic [AW-1:0]     wr_addr, rd_next_addr;
  logic              head_hit;
  logic [DATA_W-1:0] mem_rdata;

  srf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .push_i         (push_i),
    .pop_i          (pop_i),
    .ops_o          (ops),
    .wr_addr_o      (wr_addr),
    .rd_next_addr_o (rd_next_addr),
    .head_hit_o     (head_hit),
    .count_o        (count_o),
    .full_o         (full_o),
    .empty_o        (empty_o)
  );

  srf_mem #(.DATA_W(DATA_W), .ADDR_W(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (ops.push),
    .waddr_i (wr_addr),
    .wdata_i (data_i),
    .raddr_i (rd_next_addr),
    .rdata_o (mem_rdata)
  );

  srf_head #(.DATA_W(DATA_W)) u_head (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .hit_i       (head_hit),
    .data_i      (data_i),
    .mem_rdata_i (mem_rdata),
    .data_o      (data_o)
  );

  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !(pop_i && !empty_o) && !flush_i) |=> $stable(data_o)) // R2
    else $error("head changed without pop");
  AST_ONE_ENTRY_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CW'(1) && push_i && pop_i && !flush_i) |=> (count_o == CW'(1) && data_o == $past(data_i))) // R8
    else $error("one-entry swap failed");
endmodule

// File: tb/sync_ram_fifo_tb_top.sv
module sync_ram_fifo_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic full, empty;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];

  always #5 clk = ~clk;

  sync_ram_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .push_i(push), .data_i(din),
    .pop_i(pop), .data_o(dout), .full_o(full), .empty_o(empty), .count_o(count)
  );

  function automatic bit exp_full();
    return q.size() == DEPTH;
  endfunction
  function automatic bit exp_empty();
    return q.size() == 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "count", int'(count), q.size());
    chk(tag, "full", int'(full), int'(exp_full()));
    chk(tag, "empty", int'(empty), int'(exp_empty()));
    if (q.size() > 0) chk(tag, "head", int'(dout), int'(q[0]));
  endtask

  // drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit ps, bit pp, bit fl, logic [DW-1:0] d, string tag);
    bit do_push, do_pop;
    push = ps; pop = pp; flush = fl; din = d;
    @(posedge clk);
    if (fl) q.delete();
    else begin
      do_pop  = pp && !exp_empty();
      do_push = ps && !exp_full();
      if (do_pop) void'(q.pop_front());
      if (do_push) q.push_back(d);
    end
    @(negedge clk);
    push = 1'b0; pop = 1'b0; flush = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(0, 1, 0, 16'h0, "R7");            // pop on empty ignored
    step(1, 0, 0, 16'hA001, "R3");          // push into empty
    step(0, 1, 0, 16'h0, "R3");             // pop right after
    step(1, 1, 0, 16'hA002, "R7");          // push+pop on empty: pop ignored
    step(0, 1, 0, 16'h0, "R3");
    // back-to-back stream through empty queue, no gaps
    for (int i = 0; i < 4; i++) step(1, 0, 0, 16'hB000 + DW'(i), "R3");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 16'h0, "R2");
    // full-depth burst
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 16'hC000 + DW'(i), "R5");
    step(1, 0, 0, 16'hDEAD, "R6");
    step(1, 1, 0, 16'hBEEF, "R6");          // push at full ignored even with pop
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 16'h0, "R4");
    // one-entry simultaneous push and pop
    step(1, 0, 0, 16'hE001, "R4");
    step(1, 1, 0, 16'hE002, "R8");
    step(1, 1, 0, 16'hE003, "R8");
    step(0, 0, 0, 16'h0, "R2");
    step(1, 1, 0, 16'hE004, "R8");
    // flush overrides push and pop
    step(1, 0, 0, 16'hF001, "R4");
    step(1, 1, 1, 16'hF002, "R9");
    step(1, 0, 0, 16'hF003, "R3");
    step(0, 0, 1, 16'h0, "R9");
    // random traffic with varying bias
    for (int i = 0; i < 4000; i++) begin
      int pb;
      bit ps, pp, fl;
      pb = (i / 500) % 3;
      ps = ($urandom % 10) < (pb == 0 ? 7 : (pb == 1 ? 3 : 5));
      pp = ($urandom % 10) < (pb == 0 ? 3 : (pb == 1 ? 7 : 5));
      fl = ($urandom % 200) == 0;
      step(ps, pp, fl, DW'($urandom), "R2");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule